// File: doc/BRIEF.md
# A20 Address Gate Controller

This block controls whether physical address bit 20 reaches memory. Software opens or closes the gate with a two-step exchange on a small byte-wide I/O interface. First it writes a "write output port" command (0xD1) to the command port (0x64). Then it writes a byte to the data port (0x60). That byte is latched as the controller's output port, and bit 1 of the latched byte is the gate enable.

Between writes, software polls a status byte on port 0x64. Its input-buffer-full bit reports that the controller is still consuming the previous byte.

A combinational stage sits on the address path. While the gate is closed, it forces bit 20 of the incoming 32-bit physical address to zero. Addresses just above 1 MB then wrap to the bottom of memory, as a real-mode segment of 0xFFFF plus an offset of 0xFFFF would (up to 0x10FFEF). While the gate is open, the full address passes through untouched.

Top module: `a20_gate_ctrl`

## Requirements
- R1: After synchronous reset the gate is closed, the output port holds 0x00, no command is armed and the status byte reads 0x00.
- R2: A write of 0xD1 to port 0x64 followed by a write of 0xDF to port 0x60 opens the gate on the clock edge that takes the data write.
- R3: After 0xD1, a data byte whose bit 1 is 0 (for example 0xDD) closes the gate.
- R4: A write to port 0x60 with no pending 0xD1 command leaves the gate unchanged.
- R5: Any command byte other than 0xD1 written to port 0x64 cancels a pending 0xD1, so the next data write is ignored.
- R6: One 0xD1 command arms exactly one data write; a second data write is ignored.
- R7: Status bit 1 (input buffer full) reads 1 for exactly BUSY_CYCLES cycles after each accepted write to port 0x60 or 0x64, then 0. The other status bits always read 0.
- R8: With the gate closed, address output bit 20 is 0 and every other bit equals the input.
- R9: With the gate open, the address output equals the address input on all 32 bits.
- R10: Read data is 0x00 when no read is requested or when the data port is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Byte write strobe, one cycle per write |
| io_rd | input | 1 | Read request |
| io_port | input | 8 | I/O port number (0x60 data, 0x64 command/status) |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte (status on port 0x64) |
| addr_in | input | 32 | Physical address from the core |
| addr_out | output | 32 | Physical address after the gate |
| gate_open | output | 1 | High while address bit 20 passes |

## Verification
The hardest state to reach from the ports is a cancelled arm: a 0xD1 that a later, different command has overridden. Only a following data write can reveal it, and it looks identical to a fresh arm until that write happens. The bench first opens the gate. It then issues 0xD1, a foreign command and a data byte that would close the gate, and confirms the gate stays open. It repeats a similar sequence with two data writes after one arm to show the arm is consumed.

// File: rtl/a20g_pkg.sv
package a20g_pkg;
    localparam logic [7:0] PORT_DATA   = 8'h60;
    localparam logic [7:0] PORT_CMD    = 8'h64;
    localparam logic [7:0] CMD_WR_OUTP = 8'hD1;
    localparam int         GATE_BIT    = 1;
    localparam int         IBF_BIT     = 1;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CMD  = 2'd1,
        ACC_DATA = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [7:0] data;
    } bus_acc_t;

    function automatic acc_kind_e classify(input logic wr, input logic [7:0] port);
        if (!wr)                 return ACC_NONE;
        else if (port == PORT_CMD)  return ACC_CMD;
        else if (port == PORT_DATA) return ACC_DATA;
        else                     return ACC_NONE;
    endfunction

    function automatic logic [7:0] status_byte(input logic ibf);
        logic [7:0] s;
        s = 8'h00;
        s[IBF_BIT] = ibf;
        return s;
    endfunction
endpackage

// File: rtl/a20g_busy_timer.sv
module a20g_busy_timer #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/a20g_outport.sv
module a20g_outport
    import a20g_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_acc_t   acc,
    output logic [7:0] outport,
    output logic       armed
);
    logic [7:0] outport_q;
    logic       armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outport_q <= 8'h00;
            armed_q   <= 1'b0;
        end else begin
            unique case (acc.kind)
                ACC_CMD:  armed_q <= (acc.data == CMD_WR_OUTP);
                ACC_DATA: begin
                    if (armed_q)
                        outport_q <= acc.data;
                    armed_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign outport = outport_q;
    assign armed   = armed_q;
endmodule

// File: rtl/a20g_addr_mask.sv
module a20g_addr_mask #(
    parameter int ADDR_W   = 32,
    parameter int MASK_BIT = 20
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              pass,
    output logic [ADDR_W-1:0] addr_out
);
    localparam logic [ADDR_W-1:0] CLEAR_MASK = ~(ADDR_W'(1) << MASK_BIT);

    always_comb begin
        if (pass)
            addr_out = addr_in;
        else
            addr_out = addr_in & CLEAR_MASK;
    end
endmodule

// File: rtl/a20_gate_ctrl.sv
module a20_gate_ctrl
    import a20g_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int MASK_BIT    = 20,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_port,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              gate_open
);
    bus_acc_t   acc;
    logic       ibf;
    logic       armed;
    logic [7:0] outport;

    always_comb begin
        acc.kind = classify(io_wr, io_port);
        acc.data = io_wdata;
    end

    a20g_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (acc.kind != ACC_NONE),
        .busy  (ibf)
    );

    a20g_outport u_outp (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .outport (outport),
        .armed   (armed)
    );

    assign gate_open = outport[GATE_BIT];

    a20g_addr_mask #(.ADDR_W(ADDR_W), .MASK_BIT(MASK_BIT)) u_mask (
        .addr_in  (addr_in),
        .pass     (gate_open),
        .addr_out (addr_out)
    );

    assign io_rdata = (io_rd && io_port == PORT_CMD) ? status_byte(ibf) : 8'h00;
endmodule

// File: rtl/a20_gate_ctrl_chk.sv
module a20_gate_ctrl_chk
    import a20g_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MASK_BIT = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_port,
    input logic [7:0]        io_rdata,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              gate_open,
    input logic              ibf
);
    AST_RESET_CLOSED: assert property (@(posedge clk) rst |=> !gate_open); // R1
    AST_GATE_ON_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate_open) |-> $past(io_wr && io_port == PORT_DATA)); // R4
    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (io_wr && (io_port == PORT_DATA || io_port == PORT_CMD)) |=> ibf); // R7
    AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        io_rd |-> (io_rdata[7:2] == 6'd0 && io_rdata[0] == 1'b0)); // R7
    AST_CLOSED_WRAPS: assert property (@(posedge clk) disable iff (rst)
        !gate_open |-> (addr_out[MASK_BIT] == 1'b0)); // R8
    AST_OPEN_PASSES: assert property (@(posedge clk) disable iff (rst)
        gate_open |-> (addr_out == addr_in)); // R9
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == 8'h00)); // R10
endmodule

bind a20_gate_ctrl a20_gate_ctrl_chk #(.ADDR_W(ADDR_W), .MASK_BIT(MASK_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_port   (io_port),
    .io_rdata  (io_rdata),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .gate_open (gate_open),
    .ibf       (ibf)
);

// File: tb/a20_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module a20_gate_ctrl_tb_top;
    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_port = 8'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [31:0] addr_in = 32'h0;
    logic [31:0] addr_out;
    logic        gate_open;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    a20_gate_ctrl #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd),
        .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .addr_in(addr_in), .addr_out(addr_out), .gate_open(gate_open)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] port, input logic [7:0] data);
        io_wr = 1'b1; io_port = port; io_wdata = data;
        @(posedge clk); @(negedge clk);
        io_wr = 1'b0; io_port = 8'h00;
    endtask

    task automatic idle();
        repeat (BUSY) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_status(output logic [7:0] v);
        io_rd = 1'b1; io_port = 8'h64; #1;
        v = io_rdata;
        io_rd = 1'b0; io_port = 8'h00;
    endtask

    task automatic addr_probe(input string req, input logic [31:0] a, input logic [31:0] exp);
        addr_in = a; #1;
        check(req, addr_out, exp);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        check("R1 gate", {31'd0, gate_open}, 32'd0);
        read_status(s);
        check("R1 status", {24'd0, s}, 32'h00);
        addr_probe("R8 wrap after reset", 32'h0010_0000, 32'h0000_0000);
    endtask

    task automatic t_stray_data();
        wr(8'h60, 8'hDF); idle();
        check("R4 stray data", {31'd0, gate_open}, 32'd0);
    endtask

    task automatic t_open();
        wr(8'h64, 8'hD1); idle();
        wr(8'h60, 8'hDF);
        check("R2 gate opens", {31'd0, gate_open}, 32'd1);
        addr_probe("R9 high real-mode address", 32'h0010_FFEF, 32'h0010_FFEF);
        addr_probe("R9 top address", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        idle();
    endtask

    task automatic t_busy();
        logic [7:0] s;
        wr(8'h64, 8'hAA);
        for (int i = 0; i < BUSY; i++) begin
            read_status(s);
            check("R7 ibf set", {24'd0, s}, 32'h02);
            @(posedge clk); @(negedge clk);
        end
        read_status(s);
        check("R7 ibf clear", {24'd0, s}, 32'h00);
        io_rd = 1'b1; io_port = 8'h60; #1;
        check("R10 data port read", {24'd0, io_rdata}, 32'h00);
        io_rd = 1'b0; io_port = 8'h00; #1;
        check("R10 no read", {24'd0, io_rdata}, 32'h00);
    endtask

    task automatic t_cancel();
        wr(8'h64, 8'hD1); idle();
        wr(8'h64, 8'hAD); idle();
        wr(8'h60, 8'hDD); idle();
        check("R5 cancelled arm", {31'd0, gate_open}, 32'd1);
    endtask

    task automatic t_close_once();
        wr(8'h64, 8'hD1); idle();
        wr(8'h60, 8'hDD);
        check("R3 gate closes", {31'd0, gate_open}, 32'd0);
        idle();
        wr(8'h60, 8'hDF); idle();
        check("R6 arm consumed", {31'd0, gate_open}, 32'd0);
        addr_probe("R8 wrap 0x10FFEF", 32'h0010_FFEF, 32'h0000_FFEF);
        addr_probe("R8 other bits kept", 32'hFFFF_FFFF, 32'hFFEF_FFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_stray_data();
        t_open();
        t_busy();
        t_cancel();
        t_close_once();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule